// File: doc/BRIEF.md
# Accelerator Manager Protocol Endpoint

This block sits in front of one accelerator on a packetized request/response fabric. Clients send single- or multi-beat request messages. The endpoint decides who owns the accelerator and keeps shadow copies of the owner's 128-bit status word and 64-bit page-table base. It turns instruction packets of one to three beats into a single command for the accelerator and answers on the response channel. The accelerator connects through a valid/ready command port, a valid/ready register writeback port and a busy flag.

Requests are handled strictly in order, one message at a time. Every response carries the client ID of the request that caused it. The exception is a writeback, which carries the client that owned the accelerator when the writeback was captured. Writebacks from the accelerator become two-beat write responses. These may slip in ahead of a single-beat response that has not yet been shown. A response that is already visible is never interrupted.

Request opcodes: acquire 000, instruction 001, status update 010, page-table-base update 011, release 100, unbusy 101. Values 110 and 111 are dropped without effect.

Top module: `acc_mgr_endpoint`

## Requirements
- R1: An acquire is answered with response opcode 000 and data 1 when nobody holds the accelerator or the requester already holds it, and the requester then becomes owner (`owned_o`=1, `owner_o`=its ID); otherwise the data is 0 and ownership is unchanged.
- R2: A release is answered with response opcode 011 and data 0. A release from the owner clears `owned_o` and resets `owner_o` to 0. A release from any other client leaves ownership unchanged.
- R3: A status update takes two beats, low half first. `shadow_status_o` keeps its old value after the first beat and takes {second, first} as a whole after the second beat.
- R4: A page-table-base update takes one beat, loads `shadow_ptbase_o` with its data and produces no response.
- R5: An instruction packet's first beat carries the instruction in data[31:0]. Bit 13 set means one rs1 beat follows; bit 12 set means one rs2 beat follows (after rs1 when both are set). The command then shows the instruction with rs1/rs2, and any operand that was not sent reads as 0. The command holds valid and stable until the accelerator takes it.
- R6: Each instruction packet gets exactly one acknowledgement (opcode 001, data 0) after the accelerator accepts its command.
- R7: An unbusy request is answered with opcode 100 and data 0 only once `acc_busy_i` is low.
- R8: An accepted writeback gives two write responses (opcode 010). The first beat carries the write data. The second carries the destination register number, zero-extended. The client field is the owner ID at capture time (0 when unowned).
- R9: Once `rsp_valid_o` is high, it stays high with opcode, data and client stable until `rsp_ready_i` is seen.
- R10: `req_ready_o` is low while a command waits for the accelerator, while an unbusy waits for idle, and while a single-beat response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request beat valid |
| req_ready_o | output | 1 | Request beat accepted |
| req_opcode_i | input | 3 | Request opcode (first beat of a message) |
| req_client_i | input | CLIENT_W | Requesting client ID |
| req_data_i | input | DATA_W | Request beat payload |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_ready_i | input | 1 | Response beat taken |
| rsp_opcode_o | output | 3 | Response opcode |
| rsp_client_o | output | CLIENT_W | Client the response is addressed to |
| rsp_data_o | output | DATA_W | Response beat payload |
| cmd_valid_o | output | 1 | Command to accelerator valid |
| cmd_ready_i | input | 1 | Accelerator takes command |
| cmd_inst_o | output | INST_W | Instruction word |
| cmd_rs1_o | output | DATA_W | First operand |
| cmd_rs2_o | output | DATA_W | Second operand |
| wb_valid_i | input | 1 | Accelerator register writeback valid |
| wb_ready_o | output | 1 | Writeback captured |
| wb_rd_i | input | RD_W | Destination register number |
| wb_data_i | input | DATA_W | Writeback value |
| acc_busy_i | input | 1 | Accelerator busy |
| shadow_status_o | output | 2*DATA_W | Shadow status word |
| shadow_ptbase_o | output | DATA_W | Shadow page-table base |
| owned_o | output | 1 | Accelerator currently held |
| owner_o | output | CLIENT_W | Current owner ID |

## Verification
The hardest state to reach is a response held while the response channel is stalled, with ownership contested around it. This covers a refused acquire, a release by a non-owner and a repeat acquire by the owner. Directed sequences build these with chosen client IDs and hold `rsp_ready_i` and `cmd_ready_i` low for several cycles to observe stability. A seeded random stream then mixes all six request kinds and writebacks across four clients. A bench model tracks owner, shadows and expected operands.

// File: rtl/amgr_pkg.sv
package amgr_pkg;

    typedef enum logic [2:0] {
        RQ_ACQUIRE = 3'd0,
        RQ_INST    = 3'd1,
        RQ_STATUS  = 3'd2,
        RQ_PTBASE  = 3'd3,
        RQ_RELEASE = 3'd4,
        RQ_UNBUSY  = 3'd5
    } req_op_e;

    typedef enum logic [2:0] {
        RS_ACQ     = 3'd0,
        RS_INSTACK = 3'd1,
        RS_WRITE   = 3'd2,
        RS_REL     = 3'd3,
        RS_UNBUSY  = 3'd4
    } rsp_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAT_HI,
        ST_OPND1,
        ST_OPND2,
        ST_ISSUE,
        ST_DRAIN,
        ST_RESP
    } fsm_e;

    typedef enum logic [1:0] {
        W_NONE,
        W_DATA,
        W_DEST
    } wr_ph_e;

    localparam int unsigned XS1_BIT = 13;
    localparam int unsigned XS2_BIT = 12;

endpackage

// File: rtl/amgr_owner_lock.sv
module amgr_owner_lock #(
    parameter int unsigned CLIENT_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                acq_i,
    input  logic                rel_i,
    input  logic [CLIENT_W-1:0] client_i,
    output logic                grant_o,
    output logic                owned_o,
    output logic [CLIENT_W-1:0] owner_o
);

    typedef struct packed {
        logic                owned;
        logic [CLIENT_W-1:0] owner;
    } lock_t;

    lock_t l_q, l_d;

    always_comb begin
        l_d     = l_q;
        grant_o = !l_q.owned || (l_q.owner == client_i);
        if (acq_i && grant_o) begin
            l_d.owned = 1'b1;
            l_d.owner = client_i;
        end
        if (rel_i && l_q.owned && (l_q.owner == client_i)) begin
            l_d.owned = 1'b0;
            l_d.owner = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) l_q <= '0;
        else         l_q <= l_d;
    end

    assign owned_o = l_q.owned;
    assign owner_o = l_q.owner;

endmodule

// File: rtl/amgr_shadow.sv
module amgr_shadow #(
    parameter int unsigned DATA_W = 64
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  lo_we_i,
    input  logic                  hi_we_i,
    input  logic                  ptb_we_i,
    input  logic [DATA_W-1:0]     data_i,
    output logic [2*DATA_W-1:0]   status_o,
    output logic [DATA_W-1:0]     ptbase_o
);

    localparam int unsigned STATUS_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0]   stage;
        logic [STATUS_W-1:0] status;
        logic [DATA_W-1:0]   ptbase;
    } shd_t;

    shd_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (lo_we_i)  s_d.stage  = data_i;
        if (hi_we_i)  s_d.status = {data_i, s_q.stage};
        if (ptb_we_i) s_d.ptbase = data_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign status_o = s_q.status;
    assign ptbase_o = s_q.ptbase;

endmodule

// File: rtl/amgr_wr_seq.sv
module amgr_wr_seq
    import amgr_pkg::*;
#(
    parameter int unsigned CLIENT_W = 4,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned RD_W     = 5
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wb_valid_i,
    output logic                wb_ready_o,
    input  logic [DATA_W-1:0]   wb_data_i,
    input  logic [RD_W-1:0]     wb_rd_i,
    input  logic [CLIENT_W-1:0] client_i,
    input  logic                hold_i,
    input  logic                beat_ready_i,
    output logic                active_o,
    output logic [DATA_W-1:0]   beat_data_o,
    output logic [CLIENT_W-1:0] client_o
);

    typedef struct packed {
        wr_ph_e              ph;
        logic [DATA_W-1:0]   data;
        logic [RD_W-1:0]     rd;
        logic [CLIENT_W-1:0] client;
    } wseq_t;

    wseq_t w_q, w_d;

    always_comb begin
        w_d        = w_q;
        wb_ready_o = (w_q.ph == W_NONE) && !hold_i;
        unique case (w_q.ph)
            W_NONE: if (wb_valid_i && wb_ready_o) begin
                w_d.ph     = W_DATA;
                w_d.data   = wb_data_i;
                w_d.rd     = wb_rd_i;
                w_d.client = client_i;
            end
            W_DATA: if (beat_ready_i) w_d.ph = W_DEST;
            W_DEST: if (beat_ready_i) w_d.ph = W_NONE;
            default: w_d.ph = W_NONE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) w_q <= '0;
        else         w_q <= w_d;
    end

    assign active_o    = (w_q.ph != W_NONE);
    assign beat_data_o = (w_q.ph == W_DATA) ? w_q.data
                                            : {{(DATA_W-RD_W){1'b0}}, w_q.rd};
    assign client_o    = w_q.client;

endmodule

// File: rtl/acc_mgr_endpoint.sv
module acc_mgr_endpoint
    import amgr_pkg::*;
#(
    parameter int unsigned CLIENT_W = 4,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned INST_W   = 32,
    parameter int unsigned RD_W     = 5
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  req_valid_i,
    output logic                  req_ready_o,
    input  logic [2:0]            req_opcode_i,
    input  logic [CLIENT_W-1:0]   req_client_i,
    input  logic [DATA_W-1:0]     req_data_i,
    output logic                  rsp_valid_o,
    input  logic                  rsp_ready_i,
    output logic [2:0]            rsp_opcode_o,
    output logic [CLIENT_W-1:0]   rsp_client_o,
    output logic [DATA_W-1:0]     rsp_data_o,
    output logic                  cmd_valid_o,
    input  logic                  cmd_ready_i,
    output logic [INST_W-1:0]     cmd_inst_o,
    output logic [DATA_W-1:0]     cmd_rs1_o,
    output logic [DATA_W-1:0]     cmd_rs2_o,
    input  logic                  wb_valid_i,
    output logic                  wb_ready_o,
    input  logic [RD_W-1:0]       wb_rd_i,
    input  logic [DATA_W-1:0]     wb_data_i,
    input  logic                  acc_busy_i,
    output logic [2*DATA_W-1:0]   shadow_status_o,
    output logic [DATA_W-1:0]     shadow_ptbase_o,
    output logic                  owned_o,
    output logic [CLIENT_W-1:0]   owner_o
);

    typedef struct packed {
        fsm_e                st;
        logic [INST_W-1:0]   inst;
        logic [DATA_W-1:0]   rs1;
        logic [DATA_W-1:0]   rs2;
        logic [CLIENT_W-1:0] client;
        rsp_op_e             op;
        logic                res;
        logic                pend;
    } ctl_t;

    ctl_t c_q, c_d;

    logic                req_fire;
    req_op_e             req_op;
    logic                acq, rel, grant;
    logic                lo_we, hi_we, ptb_we;
    logic                wr_active;
    logic [DATA_W-1:0]   wr_data;
    logic [CLIENT_W-1:0] wr_client;
    logic                single_fire;

    assign req_fire    = req_valid_i && req_ready_o;
    assign req_op      = req_op_e'(req_opcode_i);
    assign single_fire = c_q.pend && !wr_active && rsp_ready_i;

    amgr_owner_lock #(.CLIENT_W(CLIENT_W)) lock_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .acq_i    (acq),
        .rel_i    (rel),
        .client_i (req_client_i),
        .grant_o  (grant),
        .owned_o  (owned_o),
        .owner_o  (owner_o)
    );

    amgr_shadow #(.DATA_W(DATA_W)) shadow_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lo_we_i  (lo_we),
        .hi_we_i  (hi_we),
        .ptb_we_i (ptb_we),
        .data_i   (req_data_i),
        .status_o (shadow_status_o),
        .ptbase_o (shadow_ptbase_o)
    );

    amgr_wr_seq #(.CLIENT_W(CLIENT_W), .DATA_W(DATA_W), .RD_W(RD_W)) wseq_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wb_valid_i   (wb_valid_i),
        .wb_ready_o   (wb_ready_o),
        .wb_data_i    (wb_data_i),
        .wb_rd_i      (wb_rd_i),
        .client_i     (owner_o),
        .hold_i       (c_q.pend),
        .beat_ready_i (rsp_ready_i),
        .active_o     (wr_active),
        .beat_data_o  (wr_data),
        .client_o     (wr_client)
    );

    // Request sequencing: one message at a time, in arrival order.
    always_comb begin
        c_d         = c_q;
        req_ready_o = 1'b0;
        cmd_valid_o = 1'b0;
        acq         = 1'b0;
        rel         = 1'b0;
        lo_we       = 1'b0;
        hi_we       = 1'b0;
        ptb_we      = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                req_ready_o = 1'b1;
                if (req_fire) begin
                    c_d.client = req_client_i;
                    unique case (req_op)
                        RQ_ACQUIRE: begin
                            acq      = 1'b1;
                            c_d.op   = RS_ACQ;
                            c_d.res  = grant;
                            c_d.pend = 1'b1;
                            c_d.st   = ST_RESP;
                        end
                        RQ_RELEASE: begin
                            rel      = 1'b1;
                            c_d.op   = RS_REL;
                            c_d.res  = 1'b0;
                            c_d.pend = 1'b1;
                            c_d.st   = ST_RESP;
                        end
                        RQ_STATUS: begin
                            lo_we  = 1'b1;
                            c_d.st = ST_STAT_HI;
                        end
                        RQ_PTBASE: ptb_we = 1'b1;
                        RQ_INST: begin
                            c_d.inst = req_data_i[INST_W-1:0];
                            c_d.rs1  = '0;
                            c_d.rs2  = '0;
                            if (req_data_i[XS1_BIT])      c_d.st = ST_OPND1;
                            else if (req_data_i[XS2_BIT]) c_d.st = ST_OPND2;
                            else                          c_d.st = ST_ISSUE;
                        end
                        RQ_UNBUSY: c_d.st = ST_DRAIN;
                        default: c_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_STAT_HI: begin
                req_ready_o = 1'b1;
                if (req_fire) begin
                    hi_we  = 1'b1;
                    c_d.st = ST_IDLE;
                end
            end
            ST_OPND1: begin
                req_ready_o = 1'b1;
                if (req_fire) begin
                    c_d.rs1 = req_data_i;
                    c_d.st  = c_q.inst[XS2_BIT] ? ST_OPND2 : ST_ISSUE;
                end
            end
            ST_OPND2: begin
                req_ready_o = 1'b1;
                if (req_fire) begin
                    c_d.rs2 = req_data_i;
                    c_d.st  = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                cmd_valid_o = 1'b1;
                if (cmd_ready_i) begin
                    c_d.op   = RS_INSTACK;
                    c_d.res  = 1'b0;
                    c_d.pend = 1'b1;
                    c_d.st   = ST_RESP;
                end
            end
            ST_DRAIN: begin
                if (!acc_busy_i) begin
                    c_d.op   = RS_UNBUSY;
                    c_d.res  = 1'b0;
                    c_d.pend = 1'b1;
                    c_d.st   = ST_RESP;
                end
            end
            ST_RESP: begin
                if (single_fire) begin
                    c_d.pend = 1'b0;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    // Response channel: an active write owns it; otherwise the single beat.
    always_comb begin
        if (wr_active) begin
            rsp_valid_o  = 1'b1;
            rsp_opcode_o = RS_WRITE;
            rsp_client_o = wr_client;
            rsp_data_o   = wr_data;
        end else begin
            rsp_valid_o  = c_q.pend;
            rsp_opcode_o = c_q.op;
            rsp_client_o = c_q.client;
            rsp_data_o   = {{(DATA_W-1){1'b0}}, c_q.res};
        end
    end

    assign cmd_inst_o = c_q.inst;
    assign cmd_rs1_o  = c_q.rs1;
    assign cmd_rs2_o  = c_q.rs2;

endmodule

// File: rtl/amgr_endpoint_chk.sv
module amgr_endpoint_chk #(
    parameter int unsigned CLIENT_W = 4,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned INST_W   = 32
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  req_valid_i,
    input logic                  req_ready_o,
    input logic [2:0]            req_opcode_i,
    input logic                  rsp_valid_o,
    input logic                  rsp_ready_i,
    input logic [2:0]            rsp_opcode_o,
    input logic [CLIENT_W-1:0]   rsp_client_o,
    input logic [DATA_W-1:0]     rsp_data_o,
    input logic                  cmd_valid_o,
    input logic                  cmd_ready_i,
    input logic [INST_W-1:0]     cmd_inst_o,
    input logic [DATA_W-1:0]     cmd_rs1_o,
    input logic [DATA_W-1:0]     cmd_rs2_o,
    input logic                  wb_valid_i,
    input logic                  wb_ready_o,
    input logic [DATA_W-1:0]     wb_data_i,
    input logic [2*DATA_W-1:0]   shadow_status_o,
    input logic [DATA_W-1:0]     shadow_ptbase_o,
    input logic                  owned_o,
    input logic [CLIENT_W-1:0]   owner_o
);

    // R9
    rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_opcode_o)
            && $stable(rsp_data_o) && $stable(rsp_client_o));

    // R5
    cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_inst_o)
            && $stable(cmd_rs1_o) && $stable(cmd_rs2_o));

    // R1
    acq_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o && rsp_opcode_o == 3'd0 && rsp_data_o[0]
            |-> owned_o && owner_o == rsp_client_o);

    // R2
    own_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(owned_o) |-> $past(req_valid_i && req_ready_o && req_opcode_i == 3'd4));

    // R3
    status_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(shadow_status_o) |-> $past(req_valid_i && req_ready_o));

    // R4
    ptbase_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(shadow_ptbase_o) |-> $past(req_valid_i && req_ready_o && req_opcode_i == 3'd3));

    // R8
    wb_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_valid_i && wb_ready_o |=> rsp_valid_o && rsp_opcode_o == 3'd2
            && rsp_data_o == $past(wb_data_i));

    // R10
    inorder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |-> !req_ready_o);

endmodule

bind acc_mgr_endpoint amgr_endpoint_chk #(
    .CLIENT_W (CLIENT_W),
    .DATA_W   (DATA_W),
    .INST_W   (INST_W)
) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_opcode_i    (req_opcode_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_opcode_o    (rsp_opcode_o),
    .rsp_client_o    (rsp_client_o),
    .rsp_data_o      (rsp_data_o),
    .cmd_valid_o     (cmd_valid_o),
    .cmd_ready_i     (cmd_ready_i),
    .cmd_inst_o      (cmd_inst_o),
    .cmd_rs1_o       (cmd_rs1_o),
    .cmd_rs2_o       (cmd_rs2_o),
    .wb_valid_i      (wb_valid_i),
    .wb_ready_o      (wb_ready_o),
    .wb_data_i       (wb_data_i),
    .shadow_status_o (shadow_status_o),
    .shadow_ptbase_o (shadow_ptbase_o),
    .owned_o         (owned_o),
    .owner_o         (owner_o)
);

// File: tb/acc_mgr_endpoint_tb_top.sv
`timescale 1ns/1ps
module acc_mgr_endpoint_tb_top;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_opcode = '0;
    logic [CW-1:0] req_client = '0;
    logic [63:0]   req_data = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [2:0]    rsp_opcode;
    logic [CW-1:0] rsp_client;
    logic [63:0]   rsp_data;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [31:0]   cmd_inst;
    logic [63:0]   cmd_rs1, cmd_rs2;
    logic          wb_valid = 1'b0;
    logic          wb_ready;
    logic [4:0]    wb_rd = '0;
    logic [63:0]   wb_data = '0;
    logic          acc_busy = 1'b0;
    logic [127:0]  sh_status;
    logic [63:0]   sh_ptb;
    logic          owned;
    logic [CW-1:0] owner;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    bit            m_owned = 0;
    logic [CW-1:0] m_owner = '0;
    logic [127:0]  m_status = '0;
    logic [63:0]   m_ptb = '0;

    always #2 clk = ~clk;

    acc_mgr_endpoint #(.CLIENT_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_opcode_i(req_opcode),
        .req_client_i(req_client), .req_data_i(req_data),
        .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_opcode_o(rsp_opcode),
        .rsp_client_o(rsp_client), .rsp_data_o(rsp_data),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_inst_o(cmd_inst),
        .cmd_rs1_o(cmd_rs1), .cmd_rs2_o(cmd_rs2),
        .wb_valid_i(wb_valid), .wb_ready_o(wb_ready), .wb_rd_i(wb_rd), .wb_data_i(wb_data),
        .acc_busy_i(acc_busy), .shadow_status_o(sh_status), .shadow_ptbase_o(sh_ptb),
        .owned_o(owned), .owner_o(owner)
    );

    function automatic bit exp_grant(input logic [CW-1:0] c);
        return !m_owned || (m_owner == c);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [CW-1:0] c, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_opcode = op; req_client = c; req_data = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input logic [2:0] op, input logic [63:0] d, input logic [CW-1:0] c, input string req);
        @(negedge clk);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_opcode == op, req, 64'(rsp_opcode), 64'(op));
        chk(rsp_data == d, req, rsp_data, d);
        chk(rsp_client == c, req, 64'(rsp_client), 64'(c));
        rsp_ready = 1'b1;
        @(posedge clk);
        #1 rsp_ready = 1'b0;
    endtask

    task automatic expect_cmd(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        while (!cmd_valid) @(negedge clk);
        chk(cmd_inst == i, "R5 inst", 64'(cmd_inst), 64'(i));
        chk(cmd_rs1 == a, "R5 rs1", cmd_rs1, a);
        chk(cmd_rs2 == b, "R5 rs2", cmd_rs2, b);
        chk(!req_ready, "R10 ready low during command", 64'(req_ready), 64'd0);
        cmd_ready = 1'b1;
        @(posedge clk);
        #1 cmd_ready = 1'b0;
    endtask

    task automatic do_acquire(input logic [CW-1:0] c);
        bit g;
        g = exp_grant(c);
        send(3'd0, c, 64'hdead);
        if (g) begin m_owned = 1; m_owner = c; end
        expect_rsp(3'd0, {63'd0, g}, c, "R1 acquire result");
        chk(owned == m_owned && owner == m_owner, "R1 ownership", {59'd0, owned, owner}, {59'd0, m_owned, m_owner});
    endtask

    task automatic do_release(input logic [CW-1:0] c);
        if (m_owned && m_owner == c) begin m_owned = 0; m_owner = '0; end
        send(3'd4, c, 64'h0);
        expect_rsp(3'd3, 64'd0, c, "R2 release response");
        chk(owned == m_owned && owner == m_owner, "R2 ownership", {59'd0, owned, owner}, {59'd0, m_owned, m_owner});
    endtask

    task automatic do_status(input logic [CW-1:0] c, input logic [63:0] lo, input logic [63:0] hi);
        send(3'd2, c, lo);
        @(negedge clk);
        chk(sh_status == m_status, "R3 unchanged after low beat", sh_status[63:0], m_status[63:0]);
        send(3'd2, c, hi);
        m_status = {hi, lo};
        @(negedge clk);
        chk(sh_status == m_status, "R3 status after second beat", sh_status[127:64], m_status[127:64]);
    endtask

    task automatic do_ptb(input logic [CW-1:0] c, input logic [63:0] d);
        send(3'd3, c, d);
        m_ptb = d;
        @(negedge clk);
        chk(sh_ptb == m_ptb, "R4 ptbase", sh_ptb, m_ptb);
        @(negedge clk);
        chk(!rsp_valid, "R4 no response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_inst(input logic [CW-1:0] c, input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
        send(3'd1, c, {32'd0, i});
        if (i[13]) send(3'd1, c, a);
        if (i[12]) send(3'd1, c, b);
        expect_cmd(i, i[13] ? a : 64'd0, i[12] ? b : 64'd0);
        expect_rsp(3'd1, 64'd0, c, "R6 instruction ack");
        @(negedge clk);
        chk(!rsp_valid, "R6 single ack", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_wb(input logic [4:0] rd, input logic [63:0] d);
        logic [CW-1:0] c;
        c = m_owner;
        @(negedge clk);
        wb_valid = 1'b1; wb_rd = rd; wb_data = d;
        while (!wb_ready) @(negedge clk);
        @(posedge clk);
        #1 wb_valid = 1'b0;
        expect_rsp(3'd2, d, c, "R8 write data beat");
        expect_rsp(3'd2, {59'd0, rd}, c, "R8 write dest beat");
    endtask

    task automatic do_unbusy(input logic [CW-1:0] c);
        send(3'd5, c, 64'd0);
        expect_rsp(3'd4, 64'd0, c, "R7 unbusy ack");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_d;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !cmd_valid, "R9 reset idle outputs", {62'd0, rsp_valid, cmd_valid}, 64'd0);
        chk(!owned && req_ready, "R1 reset unowned and ready", {62'd0, owned, req_ready}, 64'd1);
        chk(sh_status == '0 && sh_ptb == '0, "R3 reset shadows", sh_ptb, 64'd0);

        do_acquire(4'd3);
        do_acquire(4'd5);
        do_acquire(4'd3);
        do_release(4'd5);
        do_status(4'd3, 64'h1111_2222_3333_4444, 64'haaaa_bbbb_cccc_dddd);
        do_ptb(4'd3, 64'h0000_0008_0012_3000);

        // R5 stalled command, no operands
        send(3'd1, 4'd3, 64'h0000_0000_0000_400b);
        repeat (2) @(negedge clk);
        chk(cmd_valid && !req_ready, "R10 held command blocks requests", {62'd0, cmd_valid, req_ready}, 64'd2);
        expect_cmd(32'h0000_400b, 64'd0, 64'd0);
        expect_rsp(3'd1, 64'd0, 4'd3, "R6 ack after stall");
        do_inst(4'd3, 32'h0000_100b, 64'h5, 64'h77);
        do_inst(4'd3, 32'h0000_300b, 64'h1234, 64'h5678);
        do_inst(4'd3, 32'h0000_200b, 64'h99, 64'h0);

        // R9 stalled response
        send(3'd0, 4'd6, 64'd0);
        @(negedge clk);
        while (!rsp_valid) @(negedge clk);
        hold_d = rsp_data;
        repeat (3) @(negedge clk);
        chk(rsp_valid && rsp_data == hold_d && rsp_opcode == 3'd0 && rsp_client == 4'd6,
            "R9 response held", rsp_data, hold_d);
        chk(!req_ready, "R10 ready low while response pending", 64'(req_ready), 64'd0);
        expect_rsp(3'd0, 64'd0, 4'd6, "R1 refused acquire");

        // R7 unbusy waits for idle
        acc_busy = 1'b1;
        send(3'd5, 4'd3, 64'd0);
        repeat (5) @(negedge clk);
        chk(!rsp_valid, "R7 no ack while busy", 64'(rsp_valid), 64'd0);
        chk(!req_ready, "R10 ready low while draining", 64'(req_ready), 64'd0);
        acc_busy = 1'b0;
        expect_rsp(3'd4, 64'd0, 4'd3, "R7 ack after idle");

        do_wb(5'd17, 64'hfeed_f00d_0bad_cafe);
        do_release(4'd3);
        do_wb(5'd31, 64'h42);

        for (int n = 0; n < 300; n++) begin
            logic [CW-1:0] c;
            c = CW'($urandom_range(0, 3));
            case ($urandom_range(0, 6))
                0: do_acquire(c);
                1: do_inst(c, $urandom, {$urandom, $urandom}, {$urandom, $urandom});
                2: do_status(c, {$urandom, $urandom}, {$urandom, $urandom});
                3: do_ptb(c, {$urandom, $urandom});
                4: do_release(c);
                5: do_unbusy(c);
                default: do_wb(5'($urandom), {$urandom, $urandom});
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule